// File: doc/BRIEF.md
# HDLC Receive Byte Queue with Packet Tags

This block sits between a bit-level HDLC deframer and a microprocessor read port. It buffers up to 19 received bytes. Each byte is stored with a 2-bit tag that says where it sits in its packet and, for a closing byte, whether the packet checked out. The tag and the data of the byte at the head of the queue are driven combinationally at all times. Software can therefore read the tag before it pops the byte.

A 2-bit fill state reports one of four conditions: empty, below the threshold, at or above the threshold, or overflow. The threshold is 15 bytes, or 5 bytes when `thr_low` is high. A held threshold event, gated by a software-loaded enable, drives the interrupt line.

If the deframer offers a byte while the queue is full, the write side shuts off. It stays off until the next flag, so the rest of that packet is lost.

Top module: `rxq_tagfifo`

## Requirements
- R1: The queue stores at most DEPTH (default 19) bytes, in arrival order.
- R2: A stored byte is tagged `01` when `wr_first` is high, `00` when neither `wr_first` nor `wr_last` is high, and `1x` when `wr_last` is high (`wr_last` wins over `wr_first`). `rd_tag[1]` marks a packet end and `rd_tag[0]` marks first/bad.
- R3: A closing byte is tagged `10` only when `wr_fcs_ok` is high and `wr_abort` is low. Otherwise it is tagged `11`.
- R4: `rd_data` and `rd_tag` show the head byte without a read strobe. When the queue is empty both are zero, and a read strobe changes nothing.
- R5: `fill_state` is `00` when empty, `01` when below the threshold, `11` when at or above it, and `10` while overflow is present. Overflow takes precedence over the other codes.
- R6: The threshold is THR_HI (15) bytes when `thr_low` is 0 and THR_LO (5) bytes when `thr_low` is 1.
- R7: When the count first reaches the threshold, a held event is set in the following cycle. The event stays set until `irq_clr` is pulsed. `irq` is the event ANDed with an enable bit. The enable bit is cleared by reset and loaded from `ien_value` when `ien_load` is high.
- R8: A write strobe while the queue is full stores nothing, raises overflow and disables writing. Later bytes are dropped until `flag_seen` is pulsed.
- R9: If `flag_seen` re-enables writing while the queue is still full, the next write overflows again.
- R10: Overflow stays reported until a `flag_seen` pulse arrives while the queue holds fewer than DEPTH bytes.
- R11: A read and a write in the same cycle on a non-empty, non-full queue are both performed, and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Byte offered by the deframer |
| wr_data | input | DW | Received byte |
| wr_first | input | 1 | Byte opens a packet |
| wr_last | input | 1 | Byte closes a packet |
| wr_fcs_ok | input | 1 | Frame check matched (valid with `wr_last`) |
| wr_abort | input | 1 | Frame aborted (valid with `wr_last`) |
| flag_seen | input | 1 | Deframer detected a flag |
| rd_stb | input | 1 | Pop the head byte |
| rd_data | output | DW | Head byte, zero when empty |
| rd_tag | output | 2 | Head byte tag, zero when empty |
| fill_state | output | 2 | Encoded fill condition |
| thr_low | input | 1 | Select the low threshold |
| ien_load | input | 1 | Load the interrupt enable |
| ien_value | input | 1 | Value for the interrupt enable |
| irq_clr | input | 1 | Clear the held threshold event |
| irq | output | 1 | Threshold interrupt |

## Verification
The bench builds the block with its default parameters: a depth of 19, 8-bit data, and thresholds of 15 and 5. These values are small enough to fill the queue completely in a few dozen cycles, which covers both threshold crossings, the full-queue spill, and a flag arriving while the queue is still full. The same build also covers draining back below full and checking that the dropped bytes never come out of the read port.

// File: rtl/rxq_pkg.sv
// Shared encodings for the tagged receive queue.
package rxq_pkg;
    // Packet-position tag stored beside each byte.
    typedef enum logic [1:0] {
        TAG_MID      = 2'b00,
        TAG_FIRST    = 2'b01,
        TAG_GOOD_END = 2'b10,
        TAG_BAD_END  = 2'b11
    } tag_t;

    // Encoded fill condition reported to software.
    typedef enum logic [1:0] {
        FS_EMPTY = 2'b00,
        FS_BELOW = 2'b01,
        FS_HIGH  = 2'b11,
        FS_OVF   = 2'b10
    } fill_t;
endpackage

// File: rtl/rxq_store.sv
// Circular byte store with a tag per entry.
// Assumes: push is never asserted when full (the write controller guarantees it).
// A pop on an empty store is ignored. Head outputs are zero when empty.
module rxq_store #(
    parameter int DEPTH = 19,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic [1:0]    push_tag,
    input  logic          pop_req,
    output logic [DW-1:0] head_data,
    output logic [1:0]    head_tag,
    output logic [CW-1:0] count
);
    localparam int EW = DW + 2;

    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;
    logic          pop;

    assign pop   = pop_req && (cnt_q != '0);
    assign count = cnt_q;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Entry storage, written on push.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= {push_tag, push_data};
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Head view: zero when nothing is stored.
    always_comb begin
        if (cnt_q != '0) begin
            head_data = mem[rd_ptr][DW-1:0];
            head_tag  = mem[rd_ptr][EW-1:DW];
        end else begin
            head_data = '0;
            head_tag  = 2'b00;
        end
    end

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    assert_empty_read_still_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && cnt_q == '0 && !push) |=> ($stable(rd_ptr) && cnt_q == '0));
    assert_rw_same_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop_req && cnt_q != '0) |=> $stable(cnt_q));
endmodule

// File: rtl/rxq_wrctl.sv
// Write-side gate: builds the entry tag, blocks writes into a full store,
// and tracks the receiver-disable and sticky overflow conditions.
// Assumes: flag_seen is a one-cycle pulse from the deframer.
module rxq_wrctl
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  logic       wr_first,
    input  logic       wr_last,
    input  logic       wr_fcs_ok,
    input  logic       wr_abort,
    input  logic       flag_seen,
    input  logic       full,
    output logic       push,
    output logic [1:0] push_tag,
    output logic       ovf
);
    logic dis_q, ovf_q, attempt, spill;

    assign attempt = wr_stb && !dis_q;
    assign push    = attempt && !full;
    assign spill   = attempt && full;
    assign ovf     = ovf_q;

    // Tag selection: a closing byte wins over an opening one.
    always_comb begin
        tag_t t;
        if (wr_last)
            t = (wr_fcs_ok && !wr_abort) ? TAG_GOOD_END : TAG_BAD_END;
        else if (wr_first)
            t = TAG_FIRST;
        else
            t = TAG_MID;
        push_tag = t;
    end

    // Receiver disable: set by a spill, released by the next flag.
    always_ff @(posedge clk) begin
        if (!rst_n)         dis_q <= 1'b0;
        else if (spill)     dis_q <= 1'b1;
        else if (flag_seen) dis_q <= 1'b0;
    end

    // Sticky overflow: released only by a flag seen below full.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovf_q <= 1'b0;
        else if (spill)              ovf_q <= 1'b1;
        else if (flag_seen && !full) ovf_q <= 1'b0;
    end

    assert_drop_while_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dis_q |-> !push);
    assert_spill_sets_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !dis_q && full) |=> (ovf_q && dis_q));
    assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    assert_ovf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(flag_seen && !full)) |=> ovf_q);
    assert_last_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && wr_last && (!wr_fcs_ok || wr_abort)) |-> push_tag == 2'b11);
endmodule

// File: rtl/rxq_level.sv
// Fill-state encoder and threshold interrupt.
// Assumes: count comes from a register. The event is set one cycle after
// the count first reaches the selected threshold.
module rxq_level
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 19,
    parameter int THR_HI = 15,
    parameter int THR_LO = 5,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          ovf,
    input  logic          thr_low,
    input  logic          ien_load,
    input  logic          ien_value,
    input  logic          irq_clr,
    output logic [1:0]    fill_state,
    output logic          irq
);
    logic [CW-1:0] thr, cnt_d;
    logic          evt_q, ien_q, reach;

    assign thr   = thr_low ? CW'(THR_LO) : CW'(THR_HI);
    assign reach = (count >= thr) && (cnt_d < thr);
    assign irq   = evt_q && ien_q;

    // Fill encoding with overflow taking precedence.
    always_comb begin
        fill_t f;
        if (ovf)                f = FS_OVF;
        else if (count == '0)   f = FS_EMPTY;
        else if (count >= thr)  f = FS_HIGH;
        else                    f = FS_BELOW;
        fill_state = f;
    end

    // Delayed count for crossing detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_d <= '0;
        else        cnt_d <= count;
    end

    // Held threshold event; a new crossing wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       evt_q <= 1'b0;
        else if (reach)   evt_q <= 1'b1;
        else if (irq_clr) evt_q <= 1'b0;
    end

    // Interrupt enable, masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        ien_q <= 1'b0;
        else if (ien_load) ien_q <= ien_value;
    end

    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_q |-> !irq);
    assert_evt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q && !irq_clr) |=> evt_q);
    assert_ovf_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> fill_state == 2'b10);
endmodule

// File: rtl/rxq_tagfifo.sv
// Tagged HDLC receive queue: write gate, byte store and level/interrupt logic.
// Assumes: deframer strobes are single-cycle and synchronous to clk.
module rxq_tagfifo #(
    parameter int DEPTH  = 19,
    parameter int DW     = 8,
    parameter int THR_HI = 15,
    parameter int THR_LO = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_first,
    input  logic          wr_last,
    input  logic          wr_fcs_ok,
    input  logic          wr_abort,
    input  logic          flag_seen,
    input  logic          rd_stb,
    output logic [DW-1:0] rd_data,
    output logic [1:0]    rd_tag,
    output logic [1:0]    fill_state,
    input  logic          thr_low,
    input  logic          ien_load,
    input  logic          ien_value,
    input  logic          irq_clr,
    output logic          irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          push, ovf, full;
    logic [1:0]    push_tag;
    logic [CW-1:0] count;

    assign full = (count == CW'(DEPTH));

    rxq_wrctl u_wrctl (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_first(wr_first),
        .wr_last(wr_last), .wr_fcs_ok(wr_fcs_ok), .wr_abort(wr_abort),
        .flag_seen(flag_seen), .full(full), .push(push),
        .push_tag(push_tag), .ovf(ovf)
    );

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(wr_data),
        .push_tag(push_tag), .pop_req(rd_stb), .head_data(rd_data),
        .head_tag(rd_tag), .count(count)
    );

    rxq_level #(.DEPTH(DEPTH), .THR_HI(THR_HI), .THR_LO(THR_LO)) u_level (
        .clk(clk), .rst_n(rst_n), .count(count), .ovf(ovf),
        .thr_low(thr_low), .ien_load(ien_load), .ien_value(ien_value),
        .irq_clr(irq_clr), .fill_state(fill_state), .irq(irq)
    );

    assert_first_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && wr_first && !wr_last) |-> push_tag == 2'b01);
endmodule

// File: tb/test_rxq_tagfifo.sv
module test_rxq_tagfifo;
    localparam int DEPTH = 19;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, wr_stb, wr_first, wr_last, wr_fcs_ok, wr_abort, flag_seen;
    logic rd_stb, thr_low, ien_load, ien_value, irq_clr, irq;
    logic [7:0] wr_data, rd_data;
    logic [1:0] rd_tag, fill_state;

    rxq_tagfifo i_rxq_tagfifo (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .wr_first(wr_first), .wr_last(wr_last), .wr_fcs_ok(wr_fcs_ok),
        .wr_abort(wr_abort), .flag_seen(flag_seen), .rd_stb(rd_stb),
        .rd_data(rd_data), .rd_tag(rd_tag), .fill_state(fill_state),
        .thr_low(thr_low), .ien_load(ien_load), .ien_value(ien_value),
        .irq_clr(irq_clr), .irq(irq)
    );

    int n_run = 0, n_fail = 0;
    logic [9:0] exp_q[$];
    int  mcnt = 0, mprev = 0;
    bit  mdis = 0, movf = 0, mevt = 0, mien = 0;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Clear strobes after each cycle.
    task automatic idle_inputs();
        wr_stb = 0; wr_first = 0; wr_last = 0; wr_fcs_ok = 0; wr_abort = 0;
        flag_seen = 0; rd_stb = 0; ien_load = 0; ien_value = 0; irq_clr = 0;
    endtask

    // One cycle: monitor the head on reads, update the model, clock.
    task automatic tick();
        int  thr;
        bit  full, att, wacc, spill, racc, set_e;
        logic [1:0] tg;
        thr = thr_low ? 5 : 15;
        if (rd_stb) begin
            if (mcnt > 0) begin
                chk("R4/R1 head data", rd_data, exp_q[0][7:0]);
                chk("R2/R3 head tag", rd_tag, exp_q[0][9:8]);
            end else begin
                chk("R4 empty data", rd_data, 0);
                chk("R4 empty tag", rd_tag, 0);
            end
        end
        full  = (mcnt == DEPTH);
        att   = wr_stb && !mdis;
        wacc  = att && !full;
        spill = att && full;
        racc  = rd_stb && mcnt > 0;
        set_e = (mcnt >= thr) && (mprev < thr);
        if (spill) movf = 1; else if (flag_seen && !full) movf = 0;
        if (spill) mdis = 1; else if (flag_seen) mdis = 0;
        tg = wr_last ? ((wr_fcs_ok && !wr_abort) ? 2'b10 : 2'b11) : (wr_first ? 2'b01 : 2'b00);
        if (wacc) exp_q.push_back({tg, wr_data});
        if (racc) void'(exp_q.pop_front());
        mprev = mcnt;
        mcnt  = mcnt + int'(wacc) - int'(racc);
        if (set_e) mevt = 1; else if (irq_clr) mevt = 0;
        if (ien_load) mien = ien_value;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic chk_state(input string rq);
        int thr;
        logic [1:0] ef;
        thr = thr_low ? 5 : 15;
        ef = movf ? 2'b10 : (mcnt == 0 ? 2'b00 : (mcnt >= thr ? 2'b11 : 2'b01));
        chk({rq, " fill"}, fill_state, ef);
        chk({rq, " irq"}, irq, mevt && mien);
    endtask

    task automatic put(input logic [7:0] d, input bit f, input bit l, input bit ok, input bit ab);
        wr_stb = 1; wr_data = d; wr_first = f; wr_last = l; wr_fcs_ok = ok; wr_abort = ab;
        tick();
    endtask

    task automatic get();
        rd_stb = 1;
        tick();
    endtask

    task automatic drain(input string rq);
        while (mcnt > 0) get();
        chk_state(rq);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle_inputs();
        wr_data = 0; thr_low = 0; rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        chk("R5 reset fill", fill_state, 2'b00);
        chk("R7 reset irq", irq, 0);
        chk("R4 reset data", rd_data, 0);

        // R7: enable interrupts
        ien_load = 1; ien_value = 1; tick();

        // R2 good packet
        put(8'h11, 1, 0, 0, 0); chk_state("R5 one byte");
        put(8'h22, 0, 0, 0, 0);
        put(8'h33, 0, 1, 1, 0);
        drain("R2 good packet");

        // R3 bad FCS and abort
        put(8'h41, 1, 0, 0, 0); put(8'h42, 0, 1, 0, 0);
        put(8'h51, 1, 0, 0, 0); put(8'h52, 0, 0, 0, 0); put(8'h53, 0, 1, 1, 1);
        put(8'h61, 1, 1, 1, 0);
        drain("R3 bad endings");

        // R4 empty read leaves pointers alone
        get(); chk_state("R4 empty read");
        put(8'h77, 1, 0, 0, 0); get(); chk_state("R4 after empty read");

        // R11 simultaneous read and write
        put(8'h81, 1, 0, 0, 0); put(8'h82, 0, 0, 0, 0);
        wr_stb = 1; wr_data = 8'h83; rd_stb = 1; tick();
        chk_state("R11 rw"); chk("R11 count kept", rd_data, 8'h82);
        drain("R11 drain");

        // R6/R7 high threshold
        for (int i = 0; i < 14; i++) put(8'(8'h90 + i), i == 0, 0, 0, 0);
        chk_state("R6 fourteen");
        put(8'h9e, 0, 0, 0, 0); chk_state("R6 fifteen");
        tick(); chk_state("R7 irq raised"); chk("R7 irq on", irq, 1);
        tick(); chk("R7 held", irq, 1);
        irq_clr = 1; tick(); chk("R7 cleared", irq, 0);
        drain("R6 drain");

        // R6 low threshold, R7 masking with held event
        thr_low = 1;
        for (int i = 0; i < 4; i++) put(8'(8'ha0 + i), 0, 0, 0, 0);
        chk_state("R6 low four");
        put(8'ha4, 0, 0, 0, 0); chk_state("R6 low five");
        ien_load = 1; ien_value = 0; tick(); chk("R7 masked", irq, 0);
        ien_load = 1; ien_value = 1; tick(); chk("R7 unmask held", irq, 1);
        irq_clr = 1; tick();
        drain("R6 low drain");
        thr_low = 0;

        // R8 overflow
        for (int i = 0; i < DEPTH; i++) put(8'(8'hc0 + i), i == 0, 0, 0, 0);
        chk_state("R1 full");
        put(8'hee, 0, 0, 0, 0); chk_state("R8 spill");
        put(8'hef, 0, 0, 0, 0); put(8'hf0, 0, 1, 1, 0); chk_state("R8 dropped");
        // R9 flag while still full
        flag_seen = 1; tick(); chk_state("R9 flag full");
        put(8'hf1, 1, 0, 0, 0); chk_state("R9 spill again");
        // R10 sticky until flag below full
        get(); chk_state("R10 below full no flag");
        flag_seen = 1; tick(); chk_state("R10 released");
        put(8'hf2, 1, 0, 0, 0); put(8'hf3, 0, 0, 0, 0); chk_state("R8 second spill");
        irq_clr = 1; tick();
        drain("R8 drain");
        flag_seen = 1; tick(); chk_state("R10 empty release");
        put(8'hf4, 1, 1, 1, 0); drain("R8 resumed");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule